// File: doc/BRIEF.md
# NAND Command and Address Front End

This block is the device-side front end of a small-page NAND memory. It watches an 8-bit I/O bus together with a command-latch enable, an address-latch enable, an active-low write strobe and an active-low read strobe. The block samples the strobes on the system clock and treats each rising edge of the write strobe as one bus cycle. The state of the two latch enables sorts each byte into a command, an address byte or a data byte.

The block keeps a column pointer. Three commands select which region of the page the pointer refers to, and the setting stays in place across later operations until another of those commands changes it. The block collects the three address bytes of reads and programs, the two row bytes of a block erase, and the confirm commands. When a sequence is complete it reports a decoded operation code. It also reports the collected address and the effective starting column. An identification sequence makes the block return two fixed code bytes on later read strobes.

Top module: `nand_cmd_front`

## Requirements
- R1: A byte is taken as a command only on a rising edge of `we_n` while `cle` is high and `ale` is low. It is taken as an address byte when `ale` is high and `cle` is low, and as a data byte when both are low. No byte is taken without a rising edge of `we_n`.
- R2: A read command followed by three address bytes pulses `op_done` for one cycle with `op_code` = 1 (read). `addr_out` holds the bytes as {third, second, first}. The other codes are 0 none, 2 program, 3 erase and 4 identify.
- R3: Command 00h sets the pointer to the low main half (`area` 0), 01h sets it to the high main half (1), and 50h sets it to the spare region (2). Each of these starts a read. The pointer keeps its value through program and erase sequences.
- R4: `start_col` equals the first address byte when `area` is 0. It equals 256 plus that byte when `area` is 1. It equals 512 plus the low four bits of that byte when `area` is 2.
- R5: After reset, `area` is 0, `op_code` is 0, `addr_out` is 0, `op_done` and `data_load` are 0, and `id_active` is 0.
- R6: Command 90h followed by the address byte 00h pulses `op_done` with `op_code` 4 and sets `id_active`. `id_out` then shows ECh, shows E3h after the first rising edge of `re_n`, and shows 00h after the second.
- R7: After 90h, an address byte other than 00h leaves `id_active` low and `id_out` at 00h.
- R8: Command 60h, two address bytes stored as the second and third bytes of `addr_out`, and then D0h pulse `op_done` with `op_code` 3. D0h that comes before both row bytes have arrived completes nothing.
- R9: Command 80h, three address bytes, any data bytes and then 10h pulse `op_done` with `op_code` 2. A data byte pulses `data_load` only after all three program address bytes have been received.
- R10: Any command byte other than 00h, 01h, 50h, 80h, 10h, 60h, D0h and 90h clears `addr_out` to zero, abandons any partial sequence and leaves `area` unchanged. 10h or D0h that arrives out of its sequence is handled the same way.
- R11: A byte strobed while `cle` and `ale` are both high changes nothing. It counts as neither a command nor an address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| io_in | input | 8 | I/O bus byte |
| cle | input | 1 | Command-latch enable |
| ale | input | 1 | Address-latch enable |
| we_n | input | 1 | Active-low write strobe, byte taken on its rising edge |
| re_n | input | 1 | Active-low read strobe, ID index advances on its rising edge |
| op_done | output | 1 | One-cycle pulse when an operation sequence completes |
| op_code | output | 3 | Last completed operation |
| addr_out | output | 24 | Collected address bytes {third, second, first} |
| start_col | output | 10 | Effective starting column |
| area | output | 2 | Current pointer region |
| data_load | output | 1 | One-cycle pulse for a data byte during program load |
| id_active | output | 1 | Identification output mode |
| id_out | output | 8 | Identification byte |

## Verification
The assertions check the following on every cycle. A byte strobed with both latch enables high leaves the sequence phase and the pointer untouched. An unknown command clears the address without moving the pointer. Every completion pulse follows a write edge. The identification byte is zero outside ID mode. The spare-region column always stays between 512 and 527. Only the bench scenarios can show that whole sequences produce the right operation code, that the pointer survives program and erase sequences, that the address bytes go to the right positions, and that the two ID bytes come out in order.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 3;
    localparam int COL_W      = 10;
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1);

    localparam logic [BYTE_W-1:0] CMD_PTR_LO   = 8'h00;
    localparam logic [BYTE_W-1:0] CMD_PTR_HI   = 8'h01;
    localparam logic [BYTE_W-1:0] CMD_PTR_SP   = 8'h50;
    localparam logic [BYTE_W-1:0] CMD_PRG_SET  = 8'h80;
    localparam logic [BYTE_W-1:0] CMD_PRG_GO   = 8'h10;
    localparam logic [BYTE_W-1:0] CMD_ERS_SET  = 8'h60;
    localparam logic [BYTE_W-1:0] CMD_ERS_GO   = 8'hD0;
    localparam logic [BYTE_W-1:0] CMD_IDENT    = 8'h90;
    localparam logic [BYTE_W-1:0] ID_MAKER     = 8'hEC;
    localparam logic [BYTE_W-1:0] ID_DEVICE    = 8'hE3;

    typedef enum logic [1:0] {AREA_LO = 2'd0, AREA_HI = 2'd1, AREA_SP = 2'd2} area_t;
    typedef enum logic [2:0] {OP_NONE = 3'd0, OP_READ = 3'd1, OP_PROG = 3'd2,
                              OP_ERASE = 3'd3, OP_IDENT = 3'd4} op_t;
    typedef enum logic [2:0] {PH_IDLE, PH_RD_ADDR, PH_PG_ADDR, PH_PG_DATA,
                              PH_ER_ADDR, PH_ID_ADDR, PH_ID_OUT} phase_t;

    function automatic logic cmd_known(input logic [BYTE_W-1:0] c);
        return (c == CMD_PTR_LO) || (c == CMD_PTR_HI) || (c == CMD_PTR_SP) ||
               (c == CMD_PRG_SET) || (c == CMD_PRG_GO) || (c == CMD_ERS_SET) ||
               (c == CMD_ERS_GO) || (c == CMD_IDENT);
    endfunction
endpackage

// File: rtl/nand_strobe_edge.sv
module nand_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic rise
);
    logic prev_q;
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= strobe_n;
    end
    assign rise = strobe_n & ~prev_q;
endmodule

// File: rtl/nand_col_calc.sv
module nand_col_calc
    import nand_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  area_t             area,
    input  logic [BYTE_W-1:0] first_byte,
    output logic [COL_W-1:0]  col
);
    localparam int HALF = 1 << BYTE_W;
    always_comb begin
        unique case (area)
            AREA_HI: col = COL_W'(HALF) + COL_W'(first_byte);
            AREA_SP: col = COL_W'(2 * HALF) + COL_W'(first_byte[3:0]);
            default: col = COL_W'(first_byte);
        endcase
    end

    // R4: spare-region column stays inside the 16 spare columns
    a_r4_spare_window: assert property (@(posedge clk) disable iff (rst)
        (area == AREA_SP) |-> (col >= COL_W'(2 * HALF) && col < COL_W'(2 * HALF + 16)));
endmodule

// File: rtl/nand_cmd_fsm.sv
module nand_cmd_fsm
    import nand_fe_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic [BYTE_W-1:0]                io_in,
    input  logic                             cle,
    input  logic                             ale,
    input  logic                             we_rise,
    input  logic                             re_rise,
    output logic                             op_done,
    output op_t                              op_code,
    output logic [ADDR_BYTES-1:0][BYTE_W-1:0] addr,
    output area_t                            area,
    output logic                             data_load,
    output logic                             id_active,
    output logic [BYTE_W-1:0]                id_out
);
    phase_t     phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0] idx_q;

    wire is_cmd  = we_rise &  cle & ~ale;
    wire is_addr = we_rise & ~cle &  ale;
    wire is_data = we_rise & ~cle & ~ale;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);
    localparam logic [CNT_W-1:0] ROWS = CNT_W'(ADDR_BYTES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            idx_q     <= '0;
            addr      <= '0;
            area      <= AREA_LO;
            op_code   <= OP_NONE;
            op_done   <= 1'b0;
            data_load <= 1'b0;
        end else begin
            op_done   <= 1'b0;
            data_load <= 1'b0;
            if (is_cmd) begin
                cnt_q <= '0;
                if (io_in == CMD_PTR_LO || io_in == CMD_PTR_HI || io_in == CMD_PTR_SP) begin
                    phase_q <= PH_RD_ADDR;
                    area    <= (io_in == CMD_PTR_LO) ? AREA_LO :
                               (io_in == CMD_PTR_HI) ? AREA_HI : AREA_SP;
                end else if (io_in == CMD_PRG_SET) begin
                    phase_q <= PH_PG_ADDR;
                end else if (io_in == CMD_ERS_SET) begin
                    phase_q <= PH_ER_ADDR;
                end else if (io_in == CMD_IDENT) begin
                    phase_q <= PH_ID_ADDR;
                end else if (io_in == CMD_PRG_GO && phase_q == PH_PG_DATA) begin
                    phase_q <= PH_IDLE;
                    op_code <= OP_PROG;
                    op_done <= 1'b1;
                end else if (io_in == CMD_ERS_GO && phase_q == PH_ER_ADDR && cnt_q == ROWS) begin
                    phase_q <= PH_IDLE;
                    op_code <= OP_ERASE;
                    op_done <= 1'b1;
                end else begin
                    phase_q <= PH_IDLE;
                    addr    <= '0;
                end
            end else if (is_addr) begin
                unique case (phase_q)
                    PH_RD_ADDR, PH_PG_ADDR: begin
                        addr[cnt_q] <= io_in;
                        cnt_q       <= cnt_q + 1'b1;
                        if (cnt_q == LAST) begin
                            cnt_q <= '0;
                            if (phase_q == PH_RD_ADDR) begin
                                phase_q <= PH_IDLE;
                                op_code <= OP_READ;
                                op_done <= 1'b1;
                            end else begin
                                phase_q <= PH_PG_DATA;
                            end
                        end
                    end
                    PH_ER_ADDR: begin
                        if (cnt_q != ROWS) begin
                            addr[cnt_q + 1'b1] <= io_in;
                            cnt_q              <= cnt_q + 1'b1;
                        end
                    end
                    PH_ID_ADDR: begin
                        if (io_in == '0) begin
                            phase_q <= PH_ID_OUT;
                            idx_q   <= '0;
                            op_code <= OP_IDENT;
                            op_done <= 1'b1;
                        end else begin
                            phase_q <= PH_IDLE;
                        end
                    end
                    default: ;
                endcase
            end else if (is_data) begin
                if (phase_q == PH_PG_DATA) data_load <= 1'b1;
            end
            if (re_rise && phase_q == PH_ID_OUT && idx_q != 2'd2)
                idx_q <= idx_q + 1'b1;
        end
    end

    assign id_active = (phase_q == PH_ID_OUT);
    always_comb begin
        id_out = '0;
        if (id_active) begin
            if (idx_q == 2'd0)      id_out = ID_MAKER;
            else if (idx_q == 2'd1) id_out = ID_DEVICE;
        end
    end

    // R11: both latch enables high leaves phase and pointer untouched
    a_r11_both_high_ignored: assert property (@(posedge clk) disable iff (rst)
        (we_rise && cle && ale) |=> ($stable(phase_q) && $stable(area) && $stable(addr)));
    // R10: unknown command clears the address and keeps the pointer
    a_r10_unknown_clears: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && !cmd_known(io_in)) |=> (addr == '0 && $stable(area) && phase_q == PH_IDLE));
    // R1: completion only follows a write edge
    a_r1_done_after_edge: assert property (@(posedge clk) disable iff (rst)
        op_done |-> $past(we_rise));
    // R6: identification byte is zero outside ID mode
    a_r6_id_quiet: assert property (@(posedge clk) disable iff (rst)
        !id_active |-> id_out == '0);
    // R5: state right after reset
    a_r5_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (area == AREA_LO && op_code == OP_NONE && !op_done && !id_active));
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
    import nand_fe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  io_in,
    input  logic        cle,
    input  logic        ale,
    input  logic        we_n,
    input  logic        re_n,
    output logic        op_done,
    output logic [2:0]  op_code,
    output logic [23:0] addr_out,
    output logic [9:0]  start_col,
    output logic [1:0]  area,
    output logic        data_load,
    output logic        id_active,
    output logic [7:0]  id_out
);
    logic we_rise, re_rise;
    op_t   op_q;
    area_t area_q;
    logic [ADDR_BYTES-1:0][BYTE_W-1:0] addr_q;

    nand_strobe_edge u_we (.clk(clk), .rst(rst), .strobe_n(we_n), .rise(we_rise));
    nand_strobe_edge u_re (.clk(clk), .rst(rst), .strobe_n(re_n), .rise(re_rise));

    nand_cmd_fsm u_fsm (
        .clk(clk), .rst(rst), .io_in(io_in), .cle(cle), .ale(ale),
        .we_rise(we_rise), .re_rise(re_rise), .op_done(op_done), .op_code(op_q),
        .addr(addr_q), .area(area_q), .data_load(data_load),
        .id_active(id_active), .id_out(id_out)
    );

    nand_col_calc u_col (
        .clk(clk), .rst(rst), .area(area_q), .first_byte(addr_q[0]), .col(start_col)
    );

    assign op_code  = op_q;
    assign area     = area_q;
    assign addr_out = addr_q;
endmodule

// File: tb/test_nand_cmd_front.sv
`timescale 1ns/1ps
module test_nand_cmd_front;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] io_in = '0;
    logic cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
    logic op_done, data_load, id_active;
    logic [2:0] op_code;
    logic [23:0] addr_out;
    logic [9:0] start_col;
    logic [1:0] area;
    logic [7:0] id_out;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    nand_cmd_front i_nand_cmd_front (
        .clk(clk), .rst(rst), .io_in(io_in), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .op_done(op_done), .op_code(op_code), .addr_out(addr_out),
        .start_col(start_col), .area(area), .data_load(data_load),
        .id_active(id_active), .id_out(id_out)
    );

    typedef struct packed {
        logic cle; logic ale; logic [7:0] d;
        logic done; logic [2:0] op; logic [9:0] col; logic [1:0] ar;
    } vec_t;

    localparam vec_t VEC [27] = '{
        '{1'b1,1'b0,8'h00,1'b0,3'd0,10'd0,  2'd0},
        '{1'b0,1'b1,8'h05,1'b0,3'd0,10'd5,  2'd0},
        '{1'b0,1'b1,8'h12,1'b0,3'd0,10'd5,  2'd0},
        '{1'b0,1'b1,8'h34,1'b1,3'd1,10'd5,  2'd0},
        '{1'b1,1'b0,8'h01,1'b0,3'd0,10'd261,2'd1},
        '{1'b0,1'b1,8'h07,1'b0,3'd0,10'd263,2'd1},
        '{1'b0,1'b1,8'h00,1'b0,3'd0,10'd263,2'd1},
        '{1'b0,1'b1,8'h00,1'b1,3'd1,10'd263,2'd1},
        '{1'b1,1'b0,8'h50,1'b0,3'd0,10'd519,2'd2},
        '{1'b0,1'b1,8'h3A,1'b0,3'd0,10'd522,2'd2},
        '{1'b0,1'b1,8'h01,1'b0,3'd0,10'd522,2'd2},
        '{1'b0,1'b1,8'h02,1'b1,3'd1,10'd522,2'd2},
        '{1'b1,1'b0,8'h80,1'b0,3'd0,10'd522,2'd2},
        '{1'b0,1'b1,8'h20,1'b0,3'd0,10'd512,2'd2},
        '{1'b0,1'b1,8'h01,1'b0,3'd0,10'd512,2'd2},
        '{1'b0,1'b1,8'h02,1'b0,3'd0,10'd512,2'd2},
        '{1'b0,1'b0,8'hAB,1'b0,3'd0,10'd512,2'd2},
        '{1'b1,1'b0,8'h10,1'b1,3'd2,10'd512,2'd2},
        '{1'b1,1'b0,8'h60,1'b0,3'd0,10'd512,2'd2},
        '{1'b0,1'b1,8'h11,1'b0,3'd0,10'd512,2'd2},
        '{1'b0,1'b1,8'h22,1'b0,3'd0,10'd512,2'd2},
        '{1'b1,1'b0,8'hD0,1'b1,3'd3,10'd512,2'd2},
        '{1'b1,1'b0,8'h00,1'b0,3'd0,10'd32, 2'd0},
        '{1'b0,1'b1,8'h09,1'b0,3'd0,10'd9,  2'd0},
        '{1'b1,1'b0,8'h77,1'b0,3'd0,10'd0,  2'd0},
        '{1'b1,1'b0,8'h01,1'b0,3'd0,10'd256,2'd1},
        '{1'b1,1'b0,8'hFF,1'b0,3'd0,10'd256,2'd1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic c, input logic a, input logic [7:0] d);
        @(negedge clk); cle = c; ale = a; io_in = d; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd();
        @(negedge clk); re_n = 1'b0;
        @(negedge clk); re_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 50000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        // R5 reset state
        chk("R5 area", 32'(area), 0);
        chk("R5 op_code", 32'(op_code), 0);
        chk("R5 addr", 32'(addr_out), 0);
        chk("R5 flags", {29'd0, op_done, data_load, id_active}, 0);

        // Table walk covering R1 R2 R3 R4 R8 R9 R10
        for (int i = 0; i < 27; i++) begin
            wr(VEC[i].cle, VEC[i].ale, VEC[i].d);
            chk($sformatf("R2 done v%0d", i), 32'(op_done), 32'(VEC[i].done));
            if (VEC[i].done) chk($sformatf("R2 op v%0d", i), 32'(op_code), 32'(VEC[i].op));
            chk($sformatf("R4 col v%0d", i), 32'(start_col), 32'(VEC[i].col));
            chk($sformatf("R3 area v%0d", i), 32'(area), 32'(VEC[i].ar));
            if (i == 11) chk("R2 addr order", 32'(addr_out), 32'h02013A);
            if (i == 16) chk("R9 data_load", 32'(data_load), 1);
            if (i == 21) chk("R8 erase rows", 32'(addr_out), 32'h221120);
            if (i == 24) chk("R10 addr cleared", 32'(addr_out), 0);
        end

        // R1 no strobe: bus activity without we_n edge does nothing
        do_reset();
        @(negedge clk); cle = 1'b1; io_in = 8'h50;
        repeat (3) @(negedge clk);
        chk("R1 no edge no command", 32'(area), 0);

        // R6 ID sequence
        wr(1'b1, 1'b0, 8'h90);
        wr(1'b0, 1'b1, 8'h00);
        chk("R6 id done", 32'(op_done), 1);
        chk("R6 id op", 32'(op_code), 4);
        chk("R6 id active", 32'(id_active), 1);
        chk("R6 maker", 32'(id_out), 32'hEC);
        rd();
        chk("R6 device", 32'(id_out), 32'hE3);
        rd();
        chk("R6 after two", 32'(id_out), 0);

        // R7 ID with non-zero address
        wr(1'b1, 1'b0, 8'h90);
        wr(1'b0, 1'b1, 8'h01);
        chk("R7 not active", 32'(id_active), 0);
        chk("R7 id zero", 32'(id_out), 0);

        // R11 both enables high ignored mid-read
        wr(1'b1, 1'b0, 8'h00);
        wr(1'b0, 1'b1, 8'h05);
        wr(1'b1, 1'b1, 8'h50);
        chk("R11 area kept", 32'(area), 0);
        wr(1'b0, 1'b1, 8'h06);
        chk("R11 not counted", 32'(op_done), 0);
        wr(1'b0, 1'b1, 8'h07);
        chk("R11 read completes", 32'(op_done), 1);
        chk("R11 addr", 32'(addr_out), 32'h070605);

        // R9 data outside program load ignored
        wr(1'b0, 1'b0, 8'h5A);
        chk("R9 no load outside", 32'(data_load), 0);

        // R8 premature confirm completes nothing
        wr(1'b1, 1'b0, 8'h60);
        wr(1'b0, 1'b1, 8'h01);
        wr(1'b1, 1'b0, 8'hD0);
        chk("R8 early confirm", 32'(op_done), 0);
        chk("R10 early confirm clears", 32'(addr_out), 0);

        finish_run();
    end
endmodule